// File: doc/BRIEF.md
# Wildcard Alarm Time Comparator

This block watches the five calendar fields of a real-time clock: seconds, minutes, hours, day of month and month. Each field has its own stored alarm byte. Once per second the clock counters finish their update and pulse a strobe. On that strobe the block compares every current field with its alarm byte. If all five agree, it raises an alarm flag. If the alarm interrupt was enabled at that moment, it also raises an interrupt request.

An alarm byte whose two top bits are both one is a wildcard. Valid BCD or binary time values never use that code, so the field then matches any value. Software uses wildcards to make the alarm repeat:
- seconds, minutes and hours specific, date and month wildcarded: the alarm fires once a day.
- only seconds and minutes specific: it fires once an hour.
- all five wildcarded: it fires on every update.

Bytes are compared exactly as stored. The alarm must be written in the same encoding and hour format the counters use. Timekeeping and bus decoding sit outside this block. It receives the current fields, a byte-wide write port for the alarm bytes, the enable bit, a status-read strobe and a clear strobe.

Top module: `alarm_match_unit`

## Requirements
- R1: After synchronous reset, `alarm_flag` and `alarm_irq` are 0 and all five alarm bytes are 0x00.
- R2: When `upd_done` is high and every field matches, `alarm_flag` is 1 from the next clock edge onward.
- R3: Matching fields without `upd_done` high never set `alarm_flag`.
- R4: A mismatch in any one non-wildcard field stops the flag from being set on that update.
- R5: An alarm byte with bits [7:6] = 2'b11 matches any current value of its field. Bits [7:6] = 2'b10 is an ordinary byte and must match exactly.
- R6: With all five alarm bytes wildcarded, every `upd_done` sets the flag.
- R7: A new alarm event sets `alarm_irq` only if `irq_en` is high in the update cycle. Raising `irq_en` later does not assert `alarm_irq` for a flag that is already set.
- R8: Once set, `alarm_flag` and `alarm_irq` hold until `flag_clr` or `stat_rd` is high. Both go to 0 at the next edge.
- R9: A match while the flag is set and no clear is requested is not a new event: `alarm_irq` keeps its value.
- R10: If a clear and a match arrive in the same cycle, the match wins. The flag ends at 1, and `alarm_irq` follows `irq_en` as for a new event.
- R11: With `wr_en` high, `wr_sel` 0..4 writes `wr_data` into the alarm byte for seconds, minutes, hours, date or month respectively. Selects 5..7 change no alarm byte.
- R12: Comparison is exact on all 8 bits with no format conversion. Hours alarm 0x12 does not match a counter value of 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_done | input | 1 | One-cycle strobe: time counters finished their update |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| cur_date | input | 8 | Current day of month |
| cur_month | input | 8 | Current month |
| wr_en | input | 1 | Alarm byte write enable |
| wr_sel | input | 3 | Alarm byte select (0 sec .. 4 month) |
| wr_data | input | 8 | Alarm byte write data |
| irq_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clear strobe for flag and interrupt |
| stat_rd | input | 1 | Status read strobe, clears flag and interrupt |
| alarm_flag | output | 1 | Alarm status flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The assertions check these rules on every cycle:
- the flag rises only one cycle after an update strobe.
- a matching update always leaves the flag set.
- the flag and interrupt hold until a clear arrives.
- the interrupt never stands without the flag.
- a set flag with no clear keeps the interrupt steady.
- all-wildcard alarms fire on every update.

Only the bench's scenarios show the rest:
- the exact-byte comparison and the wildcard against many time values.
- the ignored write selects.
- the late enable that must not raise an interrupt.
- the clear-and-match collision.

A behavioural model in the bench follows all of this on every clock.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int FIELD_W    = 8;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam logic [1:0] WILD_CODE = 2'b11;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4
    } field_sel_e;

    typedef struct packed {
        logic flag;
        logic irq;
    } alarm_state_t;

    function automatic logic is_wild(input field_t v);
        return v[FIELD_W-1 -: 2] == WILD_CODE;
    endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  field_t           wr_data,
    output field_vec_t       alarm_vec
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    alarm_vec[gi] <= '0;
                else if (wr_en && (wr_sel == SEL_W'(gi)))
                    alarm_vec[gi] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/field_match.sv
module field_match
    import alarm_pkg::*;
(
    input  field_vec_t alarm_vec,
    input  field_vec_t cur_vec,
    output logic       all_hit
);
    logic [NUM_FIELDS-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
            assign hit[gi] = is_wild(alarm_vec[gi]) || (alarm_vec[gi] == cur_vec[gi]);
        end
    endgenerate

    assign all_hit = &hit;
endmodule

// File: rtl/alarm_event.sv
module alarm_event
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd_done,
    input  logic all_hit,
    input  logic irq_en,
    input  logic clr_req,
    output logic alarm_flag,
    output logic alarm_irq
);
    alarm_state_t st, st_nxt;
    logic         set_ev;
    logic         fresh;

    assign set_ev = upd_done && all_hit;
    assign fresh  = set_ev && (!st.flag || clr_req);

    always_comb begin
        st_nxt = st;
        if (set_ev) begin
            st_nxt.flag = 1'b1;
            if (fresh)
                st_nxt.irq = irq_en;
        end else if (clr_req) begin
            st_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else
            st <= st_nxt;
    end

    assign alarm_flag = st.flag;
    assign alarm_irq  = st.irq;

    // R2: a matching update leaves the flag set
    a_r2_set_on_match: assert property (@(posedge clk) disable iff (rst)
        (upd_done && all_hit) |=> alarm_flag);

    // R3: the flag rises only after an update strobe
    a_r3_rise_needs_update: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(upd_done));

    // R8: hold until a clear
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_req) |=> alarm_flag);

    // R7: the interrupt never stands without the flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag);

    // R9: no second event while set
    a_r9_no_second_event: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_req) |=> $stable(alarm_irq));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_done,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    input  logic [7:0] cur_month,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       irq_en,
    input  logic       flag_clr,
    input  logic       stat_rd,
    output logic       alarm_flag,
    output logic       alarm_irq
);
    field_vec_t alarm_vec;
    field_vec_t cur_vec;
    logic       all_hit;
    logic       clr_req;

    assign cur_vec[FLD_SEC]   = cur_sec;
    assign cur_vec[FLD_MIN]   = cur_min;
    assign cur_vec[FLD_HOUR]  = cur_hour;
    assign cur_vec[FLD_DATE]  = cur_date;
    assign cur_vec[FLD_MONTH] = cur_month;
    assign clr_req = flag_clr || stat_rd;

    alarm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .alarm_vec (alarm_vec)
    );

    field_match u_match (
        .alarm_vec (alarm_vec),
        .cur_vec   (cur_vec),
        .all_hit   (all_hit)
    );

    alarm_event u_event (
        .clk        (clk),
        .rst        (rst),
        .upd_done   (upd_done),
        .all_hit    (all_hit),
        .irq_en     (irq_en),
        .clr_req    (clr_req),
        .alarm_flag (alarm_flag),
        .alarm_irq  (alarm_irq)
    );

    // R6: all-wildcard alarm bytes fire on every update
    a_r6_all_wild_fires: assert property (@(posedge clk) disable iff (rst)
        (upd_done && is_wild(alarm_vec[0]) && is_wild(alarm_vec[1]) && is_wild(alarm_vec[2])
         && is_wild(alarm_vec[3]) && is_wild(alarm_vec[4])) |=> alarm_flag);
endmodule

// File: tb/alarm_match_unit_bench.sv
`timescale 1ns/1ps
module alarm_match_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_done = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic [7:0] cur_date = 8'h00, cur_month = 8'h00;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic irq_en = 1'b0, flag_clr = 1'b0, stat_rd = 1'b0;
    logic alarm_flag, alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alarm_match_unit u_alarm_match_unit (
        .clk(clk), .rst(rst), .upd_done(upd_done),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_en(irq_en), .flag_clr(flag_clr), .stat_rd(stat_rd),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // behavioural reference model
    logic [7:0] m_alarm [5];
    bit m_flag, m_irq;

    always @(posedge clk) begin
        bit all_ok;
        bit clr;
        logic [7:0] now [5];
        now[0] = cur_sec; now[1] = cur_min; now[2] = cur_hour;
        now[3] = cur_date; now[4] = cur_month;
        if (rst) begin
            for (int k = 0; k < 5; k++) m_alarm[k] <= 8'h00;
            m_flag <= 0; m_irq <= 0;
        end else begin
            all_ok = 1;
            for (int k = 0; k < 5; k++)
                if (m_alarm[k][7:6] != 2'b11 && m_alarm[k] != now[k]) all_ok = 0;
            clr = flag_clr || stat_rd;
            if (upd_done && all_ok) begin
                if (!m_flag || clr) m_irq <= irq_en;
                m_flag <= 1;
            end else if (clr) begin
                m_flag <= 0; m_irq <= 0;
            end
            if (wr_en && wr_sel < 5) m_alarm[wr_sel] <= wr_data;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (alarm_flag !== m_flag) begin
                errors++;
                $display("FAIL R2 model flag: actual=%b expected=%b t=%0t", alarm_flag, m_flag, $time);
            end
            checks++;
            if (alarm_irq !== m_irq) begin
                errors++;
                $display("FAIL R7 model irq: actual=%b expected=%b t=%0t", alarm_irq, m_irq, $time);
            end
        end
    end

    task automatic chk(input string req, input logic f, input logic i);
        checks++;
        if (alarm_flag !== f || alarm_irq !== i) begin
            errors++;
            $display("FAIL %s: actual flag=%b irq=%b expected flag=%b irq=%b",
                     req, alarm_flag, alarm_irq, f, i);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d, mo);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; cur_month = mo;
    endtask

    task automatic update();
        @(negedge clk); upd_done = 1;
        @(negedge clk); upd_done = 0;
    endtask

    task automatic clear();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset state", 0, 0);
        // R1: alarm bytes reset to 0x00 match an all-zero time
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        update();
        chk("R1 zero alarm bytes", 1, 0);
        clear();
        chk("R8 flag_clr clears", 0, 0);

        // R11: program 12:34:56, date 15, month 06
        wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12); wr(3'd3, 8'h15); wr(3'd4, 8'h06);
        set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h06);
        repeat (4) @(negedge clk);
        chk("R3 no update no flag", 0, 0);
        irq_en = 1;
        update();
        chk("R2 R11 match sets flag and irq", 1, 1);
        repeat (3) @(negedge clk);
        chk("R8 flag holds", 1, 1);
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
        chk("R8 stat_rd clears", 0, 0);

        set_time(8'h57, 8'h34, 8'h12, 8'h15, 8'h06);
        update();
        chk("R4 seconds mismatch", 0, 0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h07);
        update();
        chk("R4 month mismatch", 0, 0);
        set_time(8'h56, 8'h34, 8'h0C, 8'h15, 8'h06);
        update();
        chk("R12 exact byte compare", 0, 0);

        // R5: hourly alarm, hour/date/month wildcarded
        wr(3'd2, 8'hC5); wr(3'd3, 8'hC0); wr(3'd4, 8'hFF);
        irq_en = 0;
        set_time(8'h56, 8'h34, 8'h03, 8'h01, 8'h11);
        update();
        chk("R5 wildcard matches, R7 irq off", 1, 0);
        irq_en = 1;
        repeat (2) @(negedge clk);
        chk("R7 late enable no irq", 1, 0);
        update();
        chk("R9 no second event", 1, 0);
        clear();
        chk("R8 clear", 0, 0);
        set_time(8'h56, 8'h35, 8'h03, 8'h01, 8'h11);
        update();
        chk("R5 minute still specific", 0, 0);

        // R10: clear and match collide
        set_time(8'h56, 8'h34, 8'h07, 8'h1F, 8'h02);
        update();
        chk("R10 pre-set", 1, 1);
        irq_en = 0;
        @(negedge clk); flag_clr = 1; upd_done = 1;
        @(negedge clk); flag_clr = 0; upd_done = 0;
        chk("R10 match wins over clear", 1, 0);
        clear();

        // R11: selects 5..7 ignored
        wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h00);
        update();
        chk("R11 ignored selects", 1, 0);
        clear();

        // R5: 0x80 is not a wildcard
        wr(3'd0, 8'h80);
        set_time(8'h00, 8'h34, 8'h07, 8'h1F, 8'h02);
        update();
        chk("R5 code 10 not wildcard", 0, 0);

        // R6: all wildcard
        wr(3'd0, 8'hC0); wr(3'd1, 8'hD1); wr(3'd2, 8'hE2); wr(3'd3, 8'hF3); wr(3'd4, 8'hC4);
        irq_en = 1;
        for (int n = 0; n < 5; n++) begin
            set_time(8'(n * 7), 8'(n * 11), 8'(n), 8'(n + 1), 8'(n + 2));
            update();
            chk("R6 all wildcard fires", 1, 1);
            clear();
            chk("R8 cleared", 0, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule